// File: doc/BRIEF.md
# Dual-Port Audio Interrupt Controller

This block gathers the FIFO events of a two-port serial audio unit into one interrupt line. Each port raises an event for its transmit FIFO and one for its receive FIFO. A rising edge on any of the four event inputs is latched into a status register. Each latched bit reaches the interrupt line only when two independent enable registers both allow it. Software clears status bits by writing zeros. It can also wipe all latched status by holding the interrupt-reset control low and then raising it again.

The same register bus sets the reset controls that go out to the two ports. Each port stays in reset while its own reset bit is low, while its clock-run bit is low, or while the global reset bit is low. The bus is a plain single-cycle write strobe with a combinational read. The FIFOs and the serial framing live outside this block.

Top module: `audio_irq_ctrl`

## Requirements
- R1: A rising edge on `evt_i[k]` sets status bit 4*k. The mapping is port A transmit at bit 0, port A receive at bit 4, port B transmit at bit 8 and port B receive at bit 12. The bit appears in the status register one clock after the edge is sampled. It stays set until it is cleared. An input that is held high does not set the bit again after a clear.
- R2: Writing to the status register (address 0) clears every status bit whose data bit is 0 and keeps every bit whose data bit is 1. One port's bits can therefore be cleared without touching the other port's bits.
- R3: When an event edge and a status write that clears the same bit fall in the same cycle, the bit ends up set.
- R4: `irq_o` is a register holding the OR, over the four sources, of status AND enable register 1 (address 1) AND enable register 2 (address 2). A source needs its bit set in both enable registers. `irq_o` follows a change in status or in an enable register one clock later.
- R5: The interrupt-reset bit is bit 4 of the soft-reset register (address 3). While this bit is 0, status is held at zero and events are dropped. Driving it to 0 and then back to 1 therefore leaves all status cleared.
- R6: The global reset bit is bit 0 of the soft-reset register. While it is 0, status and both enable registers are held at zero and enable writes are ignored. Both port reset outputs are also asserted while it is 0.
- R7: `port_rst_n_o[0]` is 1 only when three bits are all 1: the port A reset bit (bit 8 of address 3), the global reset bit, and the port A clock-run bit (bit 0 of address 4). `port_rst_n_o[1]` uses the port B reset bit (bit 12 of address 3), the global reset bit, and the port B clock-run bit (bit 4 of address 4).
- R8: The enable registers store only the low 24 bits of a write. Reading status, the soft-reset register or the clock-run register returns only its defined bits. Unmapped addresses read 0.
- R9: After reset, status and both enable registers read 0, the soft-reset register reads 0x1111, the clock-run register reads 0, `irq_o` is 0 and both port reset outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | AW (3) | Register word address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Combinational read data for `bus_addr` |
| evt_i | input | 4 | Events: A transmit, A receive, B transmit, B receive |
| irq_o | output | 1 | Registered interrupt line |
| port_rst_n_o | output | 2 | Active-low reset to port A (bit 0) and port B (bit 1) |

## Verification
Each result has a fixed latency, and each check reads it at that point:

| Result | When it is due |
|---|---|
| Status bit | Readable one clock after its event edge or clearing write is sampled. |
| Global reset and interrupt reset | Take hold one clock after the control write commits, so status is read one further cycle later. |
| `irq_o` | Lags status and the enable registers by one more register stage. The bench checks that it is still low on the cycle right after the enabling write and high on the cycle after that. |
| Port reset outputs | Follow the control registers combinationally, so they are checked at the falling edge that ends the write. |

All inputs are driven and all outputs sampled on falling edges, away from the active edge.

// File: rtl/audio_irq_ctrl.sv
module audio_irq_ctrl #(
  parameter int AW     = 3,
  parameter int DW     = 32,
  parameter int KEEP_W = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [3:0]    evt_i,
  output logic          irq_o,
  output logic [1:0]    port_rst_n_o
);
  localparam logic [AW-1:0] A_ST   = AW'(0);
  localparam logic [AW-1:0] A_EN1  = AW'(1);
  localparam logic [AW-1:0] A_EN2  = AW'(2);
  localparam logic [AW-1:0] A_SRST = AW'(3);
  localparam logic [AW-1:0] A_CRUN = AW'(4);
  localparam int PAD = DW - KEEP_W;

  logic [3:0]        st, evt_q, sw, nib_w;
  logic [1:0]        crun;
  logic [KEEP_W-1:0] en1, en2, st_vec, sw_vec, crun_vec;
  logic              wr_st, live, glob_ok;

  assign nib_w   = {bus_wdata[12], bus_wdata[8], bus_wdata[4], bus_wdata[0]};
  assign wr_st   = bus_we && bus_addr == A_ST;
  assign glob_ok = sw[0];
  assign live    = sw[0] && sw[1];

  always_comb begin
    st_vec   = '0;
    sw_vec   = '0;
    crun_vec = '0;
    for (int k = 0; k < 4; k++) begin
      st_vec[4*k] = st[k];
      sw_vec[4*k] = sw[k];
    end
    crun_vec[0] = crun[0];
    crun_vec[4] = crun[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      st    <= '0;
      en1   <= '0;
      en2   <= '0;
      sw    <= 4'hF;
      crun  <= '0;
      irq_o <= 1'b0;
    end else begin
      evt_q <= evt_i;
      if (!live) st <= '0;
      else       st <= (wr_st ? (st & nib_w) : st) | (evt_i & ~evt_q);
      if (!glob_ok) begin
        en1 <= '0;
        en2 <= '0;
      end else if (bus_we) begin
        if (bus_addr == A_EN1) en1 <= bus_wdata[KEEP_W-1:0];
        if (bus_addr == A_EN2) en2 <= bus_wdata[KEEP_W-1:0];
      end
      if (bus_we && bus_addr == A_SRST) sw   <= nib_w;
      if (bus_we && bus_addr == A_CRUN) crun <= {bus_wdata[4], bus_wdata[0]};
      irq_o <= |(st_vec & en1 & en2);
    end
  end

  assign port_rst_n_o[0] = sw[0] & sw[2] & crun[0];
  assign port_rst_n_o[1] = sw[0] & sw[3] & crun[1];

  always_comb begin
    case (bus_addr)
      A_ST:    bus_rdata = {{PAD{1'b0}}, st_vec};
      A_EN1:   bus_rdata = {{PAD{1'b0}}, en1};
      A_EN2:   bus_rdata = {{PAD{1'b0}}, en2};
      A_SRST:  bus_rdata = {{PAD{1'b0}}, sw_vec};
      A_CRUN:  bus_rdata = {{PAD{1'b0}}, crun_vec};
      default: bus_rdata = '0;
    endcase
  end
endmodule

module audio_irq_ctrl_chk #(
  parameter int AW     = 3,
  parameter int DW     = 32,
  parameter int KEEP_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [AW-1:0]     bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [3:0]        evt_i,
  input logic              irq_o,
  input logic [1:0]        port_rst_n_o,
  input logic [3:0]        st,
  input logic [3:0]        evt_q,
  input logic [3:0]        sw,
  input logic [KEEP_W-1:0] st_vec,
  input logic [KEEP_W-1:0] en1,
  input logic [KEEP_W-1:0] en2
);
  logic wr_st_c;
  assign wr_st_c = bus_we && bus_addr == '0;

  assert_rise_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sw[0] && sw[1] && evt_i[0] && !evt_q[0]) |=> st[0]);

  assert_status_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(st) & ~st)) |-> ($past(wr_st_c) || !$past(sw[1]) || !$past(sw[0])));

  assert_event_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st_c && sw[0] && sw[1] && evt_i[1] && !evt_q[1]) |=> st[1]);

  assert_irq_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|(st_vec & en1 & en2)));

  assert_irqrst_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sw[1] |=> (st == 4'd0));

  assert_global_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sw[0] |=> (st == 4'd0 && en1 == '0 && en2 == '0));

  assert_port_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(port_rst_n_o[0]) || $rose(port_rst_n_o[1])) |-> $past(bus_we));
endmodule

bind audio_irq_ctrl audio_irq_ctrl_chk #(.AW(AW), .DW(DW), .KEEP_W(KEEP_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .evt_i(evt_i), .irq_o(irq_o),
  .port_rst_n_o(port_rst_n_o), .st(st), .evt_q(evt_q), .sw(sw),
  .st_vec(st_vec), .en1(en1), .en2(en2)
);

// File: tb/test_audio_irq_ctrl.sv
module test_audio_irq_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  evt_i = '0;
  logic        irq_o;
  logic [1:0]  port_rst_n_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  audio_irq_ctrl i_audio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i),
    .irq_o(irq_o), .port_rst_n_o(port_rst_n_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input int k);
    @(negedge clk);
    evt_i[k] = 1'b1;
    @(negedge clk);
    evt_i[k] = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, v); chk("R9 status", v, 32'h0);
    rd(1, v); chk("R9 enable1", v, 32'h0);
    rd(2, v); chk("R9 enable2", v, 32'h0);
    rd(3, v); chk("R9 softrst", v, 32'h1111);
    rd(4, v); chk("R9 clkrun", v, 32'h0);
    chk("R9 irq", {31'd0, irq_o}, 32'h0);
    chk("R9 port resets", {30'd0, port_rst_n_o}, 32'h0);
  endtask

  task automatic t_edges;
    logic [31:0] v;
    pulse(0); rd(0, v); chk("R1 A tx bit 0", v, 32'h0001);
    pulse(1); pulse(2); pulse(3);
    rd(0, v); chk("R1 all sources", v, 32'h1111);
    wr(0, 32'h0);
    @(negedge clk); evt_i[0] = 1'b1;
    @(negedge clk);
    wr(0, 32'h0);
    @(negedge clk); @(negedge clk);
    rd(0, v); chk("R1 held level no re-set", v, 32'h0);
    evt_i[0] = 1'b0;
  endtask

  task automatic t_clear;
    logic [31:0] v;
    pulse(0); pulse(1); pulse(2); pulse(3);
    wr(0, 32'h0011);
    rd(0, v); chk("R2 clear port B only", v, 32'h0011);
    wr(0, 32'h0);
    rd(0, v); chk("R2 clear all", v, 32'h0);
  endtask

  task automatic t_same_cycle;
    logic [31:0] v;
    pulse(0);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h0; evt_i[1] = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; evt_i[1] = 1'b0;
    rd(0, v); chk("R3 event beats clear", v, 32'h0010);
    wr(0, 32'h0);
  endtask

  task automatic t_irq;
    wr(1, 32'h0001);
    pulse(0);
    @(negedge clk);
    chk("R4 one enable only", {31'd0, irq_o}, 32'h0);
    wr(2, 32'h0001);
    chk("R4 irq one cycle late", {31'd0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R4 irq both enables", {31'd0, irq_o}, 32'h1);
    pulse(3);
    wr(2, 32'h1000);
    @(negedge clk);
    chk("R4 src mismatch enables", {31'd0, irq_o}, 32'h0);
    wr(1, 32'h1000);
    @(negedge clk);
    chk("R4 port B rx source", {31'd0, irq_o}, 32'h1);
    wr(0, 32'h0);
    @(negedge clk);
    chk("R4 irq drops after clear", {31'd0, irq_o}, 32'h0);
    wr(1, 32'h0); wr(2, 32'h0);
  endtask

  task automatic t_irq_reset;
    logic [31:0] v;
    pulse(0); pulse(3);
    wr(3, 32'h1101);
    @(negedge clk);
    rd(0, v); chk("R5 status cleared while low", v, 32'h0);
    pulse(2);
    rd(0, v); chk("R5 event dropped while low", v, 32'h0);
    wr(3, 32'h1111);
    @(negedge clk);
    rd(0, v); chk("R5 still clear after rise", v, 32'h0);
    pulse(2);
    rd(0, v); chk("R5 events resume", v, 32'h0100);
    wr(0, 32'h0);
  endtask

  task automatic t_global;
    logic [31:0] v;
    wr(4, 32'h11);
    wr(1, 32'h1111); wr(2, 32'h1111);
    pulse(1);
    wr(3, 32'h1110);
    chk("R6 ports held in reset", {30'd0, port_rst_n_o}, 32'h0);
    @(negedge clk);
    rd(0, v); chk("R6 status cleared", v, 32'h0);
    rd(1, v); chk("R6 enable1 cleared", v, 32'h0);
    wr(2, 32'h1111);
    rd(2, v); chk("R6 enable write ignored", v, 32'h0);
    wr(3, 32'h1111);
    wr(2, 32'h1111);
    rd(2, v); chk("R6 enable writable again", v, 32'h1111);
    wr(2, 32'h0);
  endtask

  task automatic t_ports;
    wr(4, 32'h11);
    chk("R7 both released", {30'd0, port_rst_n_o}, 32'h3);
    wr(3, 32'h0111);
    chk("R7 port B soft reset", {30'd0, port_rst_n_o}, 32'h1);
    wr(3, 32'h1011);
    chk("R7 port A soft reset", {30'd0, port_rst_n_o}, 32'h2);
    wr(3, 32'h1111);
    wr(4, 32'h10);
    chk("R7 port A clock stopped", {30'd0, port_rst_n_o}, 32'h2);
  endtask

  task automatic t_width;
    logic [31:0] v;
    wr(1, 32'hFFFF_FFFF);
    rd(1, v); chk("R8 low 24 bits kept", v, 32'h00FF_FFFF);
    wr(3, 32'hFFFF_FFFF);
    rd(3, v); chk("R8 softrst defined bits", v, 32'h1111);
    wr(4, 32'hFFFF_FFFF);
    rd(4, v); chk("R8 clkrun defined bits", v, 32'h11);
    rd(6, v); chk("R8 unmapped reads zero", v, 32'h0);
    wr(1, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_edges;
    t_clear;
    t_same_cycle;
    t_irq;
    t_irq_reset;
    t_global;
    t_ports;
    t_width;
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule